// File: doc/BRIEF.md
# Saturating Multiply-Accumulate Unit

This block multiplies two signed operands and adds the product into a 64-bit accumulator. The accumulator is held as two 32-bit halves: a high half and a low half. There are two operation kinds. The long kind multiplies the full 32-bit operands. The word kind multiplies only the low 16 bits of each operand, taken as signed values. A saturation-mode bit is sampled together with the start strobe. It selects either plain 64-bit wrap-around or a clamp, and the clamp range depends on the operation kind.

A one-cycle `start` pulse launches an operation when the unit is idle. The accumulator update and a one-cycle `done` pulse appear two clock edges later. Each half has its own clear strobe and load strobe, so software-visible state can be set up or reset directly. These strobes override an operation that completes in the same cycle.

Top module: `satmac_unit`

## Requirements
- R1: After synchronous reset both accumulator halves read zero and `done` is low.
- R2: With `op_word`=0 and `sat_en`=0, the 64-bit accumulator {acc_hi, acc_lo} becomes the accumulator plus the signed product of `src_a` and `src_b`, modulo 2^64.
- R3: With `op_word`=1 and `sat_en`=0, the product uses only bits 15:0 of each operand as signed 16-bit values, and bits 31:16 have no effect. The sum wraps modulo 2^64.
- R4: With `op_word`=0 and `sat_en`=1, a sum inside the signed 48-bit range is written unchanged, so bits 31:15 of `acc_hi` all equal the sign of the sum.
- R5: With `op_word`=0 and `sat_en`=1, a sum above 2^47-1 writes 0x00007FFF_FFFFFFFF, and a sum below -2^47 writes 0xFFFF8000_00000000.
- R6: With `op_word`=1 and `sat_en`=1, a sum above 2^31-1 sets `acc_lo` to 0x7FFFFFFF and a sum below -2^31 sets `acc_lo` to 0x80000000. In both cases `acc_hi` becomes 1.
- R7: With `op_word`=1 and `sat_en`=1, a sum within the signed 32-bit range writes its low 32 bits to `acc_lo` and leaves `acc_hi` unchanged.
- R8: A `start` sampled while idle produces `done` high for exactly one cycle, two rising edges later. The accumulator shows the result in that same cycle.
- R9: A `start` sampled in the cycle after an accepted start is ignored. It produces no second `done` and no second accumulation.
- R10: In each half, clear beats load, and load beats a completing operation in the same cycle. The other half still takes the operation's result.
- R11: A load strobe without clear writes its data word into that half on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch request |
| op_word | input | 1 | 0 = 32x32 long kind, 1 = 16x16 word kind |
| sat_en | input | 1 | Saturation mode, sampled with start |
| src_a | input | 32 | First operand |
| src_b | input | 32 | Second operand |
| done | output | 1 | One-cycle completion pulse |
| hi_clr | input | 1 | Clear high half |
| hi_ld | input | 1 | Load high half |
| hi_wdata | input | 32 | Data for high-half load |
| lo_clr | input | 1 | Clear low half |
| lo_ld | input | 1 | Load low half |
| lo_wdata | input | 32 | Data for low-half load |
| acc_hi | output | 32 | Accumulator high half |
| acc_lo | output | 32 | Accumulator low half |

## Verification
The two functions that can meet in one cycle are a completing accumulation and a direct clear or load of an accumulator half. The bench starts an operation, then raises a clear on the high half and a load on the low half exactly at the completion edge. It checks that the high half is zero, the low half holds the loaded word, and `done` still pulses. A second case raises clear and load on the same half at that edge and expects zero in that half, while the untouched half must show the operation's result.

// File: rtl/satmac_pkg.sv
package satmac_pkg;
    parameter int unsigned MAC_WORD_W     = 32;
    parameter int unsigned MAC_SHORT_W    = 16;
    parameter int unsigned MAC_LONG_SAT_W = 48;
    localparam int unsigned MAC_ACC_W     = 2 * MAC_WORD_W;

    typedef logic [MAC_WORD_W-1:0] word_t;
    typedef logic [MAC_ACC_W-1:0]  acc_t;
    typedef logic [MAC_ACC_W:0]    wide_t;

    typedef enum logic {OP_LONG = 1'b0, OP_WORD = 1'b1} mac_op_e;

    typedef struct packed {
        mac_op_e op;
        logic    sat;
        word_t   opa;
        word_t   opb;
    } mac_req_t;

    typedef struct packed {
        logic wr_hi;
        logic wr_lo;
        acc_t value;
    } mac_res_t;

    localparam acc_t LONG_MAX = {{(MAC_ACC_W-MAC_LONG_SAT_W+1){1'b0}}, {(MAC_LONG_SAT_W-1){1'b1}}};
    localparam acc_t LONG_MIN = {{(MAC_ACC_W-MAC_LONG_SAT_W+1){1'b1}}, {(MAC_LONG_SAT_W-1){1'b0}}};
    localparam word_t WORD_MAX = {1'b0, {(MAC_WORD_W-1){1'b1}}};
    localparam word_t WORD_MIN = {1'b1, {(MAC_WORD_W-1){1'b0}}};
    localparam word_t OVF_MARK = word_t'(1);

    function automatic acc_t widen(word_t v);
        return {{MAC_WORD_W{v[MAC_WORD_W-1]}}, v};
    endfunction

    function automatic word_t short_to_word(word_t v);
        return {{(MAC_WORD_W-MAC_SHORT_W){v[MAC_SHORT_W-1]}}, v[MAC_SHORT_W-1:0]};
    endfunction

    // True when v is representable as a signed w-bit value.
    function automatic logic fits_signed(wide_t v, int unsigned w);
        logic ok;
        ok = 1'b1;
        for (int i = 0; i <= MAC_ACC_W; i++) begin
            if (i >= w && v[i] != v[w-1]) ok = 1'b0;
        end
        return ok;
    endfunction
endpackage

// File: rtl/mac_opnd_stage.sv
module mac_opnd_stage
    import satmac_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     op_word,
    input  logic     sat_en,
    input  word_t    src_a,
    input  word_t    src_b,
    output logic     busy,
    output mac_req_t req
);
    logic take;
    assign take = start && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            req  <= '0;
        end else begin
            busy <= take;
            if (take) begin
                req.op  <= op_word ? OP_WORD : OP_LONG;
                req.sat <= sat_en;
                req.opa <= op_word ? short_to_word(src_a) : src_a;
                req.opb <= op_word ? short_to_word(src_b) : src_b;
            end
        end
    end

    assert_one_cycle_busy_R9: assert property (@(posedge clk) disable iff (rst)
        busy |=> !busy);
    assert_idle_take_R8: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> busy);
endmodule

// File: rtl/mac_sat_add.sv
module mac_sat_add
    import satmac_pkg::*;
(
    input  mac_req_t req,
    input  word_t    acc_hi,
    input  word_t    acc_lo,
    output mac_res_t res
);
    acc_t  prod;
    acc_t  acc;
    wide_t sum;

    always_comb begin
        prod = widen(req.opa) * widen(req.opb);
        acc  = {acc_hi, acc_lo};
        sum  = {acc[MAC_ACC_W-1], acc} + {prod[MAC_ACC_W-1], prod};
        res.wr_hi = 1'b1;
        res.wr_lo = 1'b1;
        res.value = sum[MAC_ACC_W-1:0];
        if (req.sat) begin
            if (req.op == OP_LONG) begin
                if (!fits_signed(sum, MAC_LONG_SAT_W))
                    res.value = sum[MAC_ACC_W] ? LONG_MIN : LONG_MAX;
            end else begin
                if (!fits_signed(sum, MAC_WORD_W))
                    res.value = {OVF_MARK, sum[MAC_ACC_W] ? WORD_MIN : WORD_MAX};
                else
                    res.wr_hi = 1'b0;
            end
        end
    end
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank
    import satmac_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     hi_clr,
    input  logic     hi_ld,
    input  word_t    hi_wdata,
    input  logic     lo_clr,
    input  logic     lo_ld,
    input  word_t    lo_wdata,
    input  logic     res_vld,
    input  mac_res_t res,
    output word_t    acc_hi,
    output word_t    acc_lo
);
    localparam int unsigned HALVES = 2;

    logic [HALVES-1:0]                 clr_v, ld_v, wr_v;
    logic [HALVES-1:0][MAC_WORD_W-1:0] wd_v, rv_v, q_v;

    assign clr_v = {hi_clr, lo_clr};
    assign ld_v  = {hi_ld, lo_ld};
    assign wr_v  = {res.wr_hi, res.wr_lo};
    assign wd_v  = {hi_wdata, lo_wdata};
    assign rv_v  = res.value;

    for (genvar h = 0; h < HALVES; h++) begin : g_half
        word_t r;
        always_ff @(posedge clk) begin
            if (rst)                      r <= '0;
            else if (clr_v[h])            r <= '0;
            else if (ld_v[h])             r <= wd_v[h];
            else if (res_vld && wr_v[h])  r <= rv_v[h];
        end
        assign q_v[h] = r;

        assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
            clr_v[h] |=> (r == '0));
        assert_load_write_R11: assert property (@(posedge clk) disable iff (rst)
            (ld_v[h] && !clr_v[h]) |=> (r == $past(wd_v[h])));
    end

    assign acc_hi = q_v[1];
    assign acc_lo = q_v[0];
endmodule

// File: rtl/satmac_unit.sv
module satmac_unit
    import satmac_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        op_word,
    input  logic        sat_en,
    input  logic [31:0] src_a,
    input  logic [31:0] src_b,
    output logic        done,
    input  logic        hi_clr,
    input  logic        hi_ld,
    input  logic [31:0] hi_wdata,
    input  logic        lo_clr,
    input  logic        lo_ld,
    input  logic [31:0] lo_wdata,
    output logic [31:0] acc_hi,
    output logic [31:0] acc_lo
);
    logic     busy;
    mac_req_t req;
    mac_res_t res;

    mac_opnd_stage u_stage (
        .clk(clk), .rst(rst), .start(start), .op_word(op_word), .sat_en(sat_en),
        .src_a(src_a), .src_b(src_b), .busy(busy), .req(req)
    );

    mac_sat_add u_add (
        .req(req), .acc_hi(acc_hi), .acc_lo(acc_lo), .res(res)
    );

    mac_acc_bank u_bank (
        .clk(clk), .rst(rst),
        .hi_clr(hi_clr), .hi_ld(hi_ld), .hi_wdata(hi_wdata),
        .lo_clr(lo_clr), .lo_ld(lo_ld), .lo_wdata(lo_wdata),
        .res_vld(busy), .res(res), .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    always_ff @(posedge clk) begin
        if (rst) done <= 1'b0;
        else     done <= busy;
    end

    assert_done_follows_R8: assert property (@(posedge clk) disable iff (rst)
        busy |=> done);
    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    assert_long_range_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && req.op == OP_LONG && req.sat && !hi_clr && !hi_ld)
        |=> (acc_hi[31:15] == '0 || acc_hi[31:15] == '1));
endmodule

// File: tb/sim_satmac_unit.sv
`timescale 1ns/1ps
module sim_satmac_unit;
    logic        clk = 1'b0;
    logic        rst, start, op_word, sat_en;
    logic [31:0] src_a, src_b;
    logic        done;
    logic        hi_clr, hi_ld, lo_clr, lo_ld;
    logic [31:0] hi_wdata, lo_wdata, acc_hi, acc_lo;

    int checks = 0;
    int errors = 0;
    logic [31:0] mh, ml;

    always #2.5 clk = ~clk;

    satmac_unit u0 (
        .clk(clk), .rst(rst), .start(start), .op_word(op_word), .sat_en(sat_en),
        .src_a(src_a), .src_b(src_b), .done(done),
        .hi_clr(hi_clr), .hi_ld(hi_ld), .hi_wdata(hi_wdata),
        .lo_clr(lo_clr), .lo_ld(lo_ld), .lo_wdata(lo_wdata),
        .acc_hi(acc_hi), .acc_lo(acc_lo)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model(input bit word, input bit sat, input logic [31:0] a, input logic [31:0] b);
        longint p, s;
        if (word) p = longint'($signed(a[15:0])) * longint'($signed(b[15:0]));
        else      p = longint'($signed(a)) * longint'($signed(b));
        s = longint'({mh, ml}) + p;
        if (sat && !word) begin
            if (s > 64'sh00007FFFFFFFFFFF)      s = 64'sh00007FFFFFFFFFFF;
            else if (s < -64'sh0000800000000000) s = -64'sh0000800000000000;
            {mh, ml} = s;
        end else if (sat && word) begin
            if (s > 64'sh7FFFFFFF)              begin mh = 32'd1; ml = 32'h7FFFFFFF; end
            else if (s < -64'sh80000000)        begin mh = 32'd1; ml = 32'h80000000; end
            else                                ml = s[31:0];
        end else begin
            {mh, ml} = s;
        end
    endtask

    task automatic run_op(input string tag, input bit word, input bit sat,
                          input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        start = 1'b1; op_word = word; sat_en = sat; src_a = a; src_b = b;
        @(negedge clk);
        start = 1'b0;
        chk({tag, " R8 done early"}, {63'd0, done}, 64'd0);
        @(negedge clk);
        model(word, sat, a, b);
        chk({tag, " R8 done"}, {63'd0, done}, 64'd1);
        chk({tag, " acc"}, {acc_hi, acc_lo}, {mh, ml});
        @(negedge clk);
        chk({tag, " R8 done drop"}, {63'd0, done}, 64'd0);
    endtask

    task automatic set_acc(input logic [31:0] h, input logic [31:0] l);
        @(negedge clk);
        hi_ld = 1'b1; lo_ld = 1'b1; hi_wdata = h; lo_wdata = l;
        @(negedge clk);
        hi_ld = 1'b0; lo_ld = 1'b0;
        mh = h; ml = l;
        chk("R11 load", {acc_hi, acc_lo}, {h, l});
    endtask

    task automatic t_reset;
        chk("R1 reset acc", {acc_hi, acc_lo}, 64'd0);
        chk("R1 reset done", {63'd0, done}, 64'd0);
    endtask

    task automatic t_long_wrap;
        run_op("R2 neg", 1'b0, 1'b0, 32'hFFFFFFFD, 32'd7);
        run_op("R2 big", 1'b0, 1'b0, 32'h40000000, 32'h40000000);
        set_acc(32'h7FFFFFFF, 32'hFFFFFFFF);
        run_op("R2 wrap", 1'b0, 1'b0, 32'd1, 32'd1);
    endtask

    task automatic t_word_wrap;
        set_acc(32'd0, 32'd0);
        run_op("R3 upper ignored", 1'b1, 1'b0, 32'h1234FFFE, 32'hABCD0005);
        run_op("R3 min sq", 1'b1, 1'b0, 32'h00008000, 32'hFFFF8000);
    endtask

    task automatic t_long_sat;
        set_acc(32'd0, 32'd0);
        run_op("R4 in range", 1'b0, 1'b1, -32'sd1000, 32'd1000);
        set_acc(32'h00007FFF, 32'hFFFFFF00);
        run_op("R5 clamp hi", 1'b0, 1'b1, 32'h100, 32'h100);
        set_acc(32'hFFFF8000, 32'h00000010);
        run_op("R5 clamp lo", 1'b0, 1'b1, 32'hFFFFFFFF, 32'h100);
    endtask

    task automatic t_word_sat;
        set_acc(32'd0, 32'h7FFFFFF0);
        run_op("R6 clamp hi", 1'b1, 1'b1, 32'h10, 32'h1);
        set_acc(32'hFFFFFFFF, 32'h80000005);
        run_op("R6 clamp lo", 1'b1, 1'b1, 32'h0000FFF8, 32'h1);
        set_acc(32'd0, 32'd5);
        run_op("R7 hi kept", 1'b1, 1'b1, 32'hFFFFFFFE, 32'd5);
    endtask

    task automatic t_busy_start;
        set_acc(32'd0, 32'd100);
        @(negedge clk);
        start = 1'b1; op_word = 1'b0; sat_en = 1'b0; src_a = 32'd3; src_b = 32'd4;
        @(negedge clk);
        src_a = 32'd1000; src_b = 32'd1000;
        @(negedge clk);
        start = 1'b0;
        model(1'b0, 1'b0, 32'd3, 32'd4);
        chk("R9 first done", {63'd0, done}, 64'd1);
        chk("R9 first acc", {acc_hi, acc_lo}, {mh, ml});
        @(negedge clk);
        chk("R9 no second done", {63'd0, done}, 64'd0);
        @(negedge clk);
        chk("R9 no second done late", {63'd0, done}, 64'd0);
        chk("R9 acc unchanged", {acc_hi, acc_lo}, {mh, ml});
    endtask

    task automatic t_priority;
        set_acc(32'd7, 32'd9);
        @(negedge clk);
        start = 1'b1; op_word = 1'b0; sat_en = 1'b0; src_a = 32'd2; src_b = 32'd3;
        @(negedge clk);
        start = 1'b0; hi_clr = 1'b1; lo_ld = 1'b1; lo_wdata = 32'hCAFE0001;
        @(negedge clk);
        hi_clr = 1'b0; lo_ld = 1'b0;
        chk("R10 done kept", {63'd0, done}, 64'd1);
        chk("R10 clr and ld win", {acc_hi, acc_lo}, {32'd0, 32'hCAFE0001});
        set_acc(32'd1, 32'd10);
        @(negedge clk);
        start = 1'b1; src_a = 32'd2; src_b = 32'd3;
        @(negedge clk);
        start = 1'b0; lo_clr = 1'b1; lo_ld = 1'b1; lo_wdata = 32'h55;
        @(negedge clk);
        lo_clr = 1'b0; lo_ld = 1'b0;
        chk("R10 clear over load, hi from op", {acc_hi, acc_lo}, {32'd1, 32'd0});
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; start = 1'b0; op_word = 1'b0; sat_en = 1'b0;
        src_a = '0; src_b = '0; hi_clr = 1'b0; hi_ld = 1'b0; lo_clr = 1'b0; lo_ld = 1'b0;
        hi_wdata = '0; lo_wdata = '0; mh = '0; ml = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_long_wrap();
        t_word_wrap();
        t_long_sat();
        t_word_sat();
        t_busy_start();
        t_priority();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule